// File: doc/BRIEF.md
# StreamID Span Match Filter

This block decides, for every counter of an event-counting unit, whether a transaction carrying a given StreamID counts. Each counter has a 32-bit match pattern and a span flag. With the span flag clear, only a StreamID equal to the whole pattern counts. With the span flag set, the pattern also sets how many low bits to ignore. The trailing run of ones in the pattern, together with the zero that ends it, marks the bits that do not take part in the compare. The bits above that zero must equal the StreamID.

Software writes a pattern and a span flag to one counter at a time through a simple write port. Transactions arrive as a StreamID with a valid strobe. One clock later, the block gives a registered hit vector with one bit per counter. A global-mode input makes every counter use counter 0's settings. After reset every counter holds the pass-all setting: span set, pattern all ones.

Top module: `sid_span_filter`

## Requirements
- R1: After reset every counter holds pattern 0xFFFFFFFF with span set, and `hit_o` is all zeros. Any StreamID presented before the first write therefore hits on every counter.
- R2: With span clear, a counter hits only when the StreamID equals its 32-bit pattern exactly. This holds for pattern 0xFFFFFFFF too, which then matches only 0xFFFFFFFF.
- R3: With span set, the pattern's trailing ones and the first zero above them are ignored, and all higher bits must equal the StreamID. Pattern 0x42 hits 0x42 and 0x43 but not 0x40 or 0x44. Pattern 0x0F hits 0x00 through 0x1F. Pattern 0x7FFFFFFF hits every StreamID.
- R4: With span set and pattern 0xFFFFFFFF, the counter hits on every valid StreamID.
- R5: `hit_o` is registered. It reflects the StreamID presented in the previous cycle, and it is all zeros in any cycle whose previous cycle had `sid_valid` low.
- R6: While `global_mode` is 1, every counter's hit is computed from counter 0's pattern and span, so all bits of `hit_o` are equal.
- R7: A write takes effect for StreamIDs presented in later cycles. A StreamID presented in the same cycle as a write is judged with the settings held before the write.
- R8: A write changes only the counter selected by `cfg_idx`. All other counters keep their settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one counter's filter settings |
| cfg_idx | input | IDX_W (2) | Counter selected by the write |
| cfg_pattern | input | 32 | Match pattern to store |
| cfg_span | input | 1 | Span flag to store (1 = span mode, 0 = exact) |
| global_mode | input | 1 | 1 = all counters use counter 0's settings |
| sid_valid | input | 1 | StreamID strobe |
| sid | input | 32 | Transaction StreamID |
| hit_o | output | NUM_CTR (4) | Per-counter hit, one cycle after the strobe |

## Verification
The assertions assume that `global_mode` is a level that holds while hits are read. They also assume that a write and a strobe in the same cycle are allowed, and that `cfg_idx` always names an existing counter. The stimulus changes all inputs only on the falling clock edge, keeps `cfg_idx` below the counter count, and switches `global_mode` only between phases. The stimulus still varies StreamIDs while the strobe is low, so the idle-output property is tested against changing data.

// File: rtl/sid_filt_pkg.sv
// Package: shared widths, the per-counter filter setting type and the
// pass-all reset value used by the StreamID span filter.
package sid_filt_pkg;
    localparam int unsigned SID_W = 32;

    typedef logic [SID_W-1:0] sid_t;

    // One counter's filter setting: span flag plus match pattern.
    typedef struct packed {
        logic span;
        sid_t pat;
    } filt_cfg_t;

    // Reset setting: span mode with an all-ones pattern accepts everything.
    localparam filt_cfg_t CFG_PASS_ALL = '{span: 1'b1, pat: '1};
endpackage

// File: rtl/sid_filt_regs.sv
// Module: sid_filt_regs
// Holds one filter setting per counter and updates the addressed counter on
// a write. Assumes cfg_idx names an existing counter; a write to any other
// index matches no slot and has no effect.
module sid_filt_regs
    import sid_filt_pkg::*;
#(
    parameter int unsigned NUM_CTR = 4,
    parameter int unsigned IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [IDX_W-1:0]            cfg_idx,
    input  sid_t                        cfg_pattern,
    input  logic                        cfg_span,
    output filt_cfg_t [NUM_CTR-1:0]     cfg_q
);
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
        logic sel;
        assign sel = cfg_we && (cfg_idx == IDX_W'(g));

        // Store the new setting when this slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[g] <= CFG_PASS_ALL;
            end else if (sel) begin
                cfg_q[g] <= '{span: cfg_span, pat: cfg_pattern};
            end
        end

        // R8: a slot that is not written keeps its setting.
        assert_slot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_idx == IDX_W'(g)) |=> $stable(cfg_q[g]));
    end
endmodule

// File: rtl/sid_filt_match.sv
// Module: sid_filt_match
// Compares one StreamID against one filter setting and registers the result.
// In span mode the ignored low bits are taken from the pattern itself: the
// trailing ones plus the zero that ends them. Assumes the setting is stable
// during the compare cycle.
module sid_filt_match
    import sid_filt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  filt_cfg_t cfg,
    input  logic      sid_valid,
    input  sid_t      sid,
    output logic      hit_q
);
    sid_t ign_mask;
    sid_t diff;
    logic match;

    // Build the ignore mask and decide exact or span equality.
    always_comb begin
        ign_mask = cfg.pat ^ (cfg.pat + sid_t'(1));
        diff     = sid ^ cfg.pat;
        if (cfg.span) begin
            match = ((diff & ~ign_mask) == '0);
        end else begin
            match = (diff == '0);
        end
    end

    // Register the hit one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= sid_valid && match;
        end
    end

    // R5: no strobe, no hit in the next cycle.
    assert_idle_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sid_valid |=> !hit_q);

    // R4: span mode with an all-ones pattern accepts every StreamID.
    assert_pass_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sid_valid && cfg.span && (&cfg.pat)) |=> hit_q);

    // R2: exact mode rejects any differing StreamID.
    assert_exact_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sid_valid && !cfg.span && (sid != cfg.pat)) |=> !hit_q);
endmodule

// File: rtl/sid_span_filter.sv
// Module: sid_span_filter
// Top of the StreamID filter: a bank of per-counter settings, a selection
// stage for global mode, and one registered matcher per counter. Assumes
// global_mode is a level held by configuration.
module sid_span_filter
    import sid_filt_pkg::*;
#(
    parameter int unsigned NUM_CTR = 4,
    parameter int unsigned IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SID_W-1:0]   cfg_pattern,
    input  logic               cfg_span,
    input  logic               global_mode,
    input  logic               sid_valid,
    input  logic [SID_W-1:0]   sid,
    output logic [NUM_CTR-1:0] hit_o
);
    filt_cfg_t [NUM_CTR-1:0] cfg_q;
    filt_cfg_t [NUM_CTR-1:0] cfg_use;

    sid_filt_regs #(
        .NUM_CTR (NUM_CTR),
        .IDX_W   (IDX_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_idx     (cfg_idx),
        .cfg_pattern (cfg_pattern),
        .cfg_span    (cfg_span),
        .cfg_q       (cfg_q)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        // Pick counter 0's setting in global mode, else the counter's own.
        always_comb begin
            cfg_use[g] = global_mode ? cfg_q[0] : cfg_q[g];
        end

        sid_filt_match u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg       (cfg_use[g]),
            .sid_valid (sid_valid),
            .sid       (sid),
            .hit_q     (hit_o[g])
        );
    end

    // R6: in global mode all counters agree on the hit.
    assert_global_uniform_R6: assert property (@(posedge clk) disable iff (!rst_n)
        global_mode |=> (hit_o == '0 || hit_o == '1));
endmodule

// File: tb/sim_sid_span_filter.sv
module sim_sid_span_filter;
    localparam int NCTR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_pattern = '0;
    logic        cfg_span = 1'b0;
    logic        global_mode = 1'b0;
    logic        sid_valid = 1'b0;
    logic [31:0] sid = '0;
    logic [NCTR-1:0] hit_o;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    bit    armed = 0;
    bit    done = 0;

    // Reference state
    logic [31:0]     m_pat [NCTR];
    bit              m_span [NCTR];
    logic [NCTR-1:0] m_exp = '0;

    always #4 clk = ~clk;

    sid_span_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_pattern(cfg_pattern), .cfg_span(cfg_span),
        .global_mode(global_mode), .sid_valid(sid_valid), .sid(sid),
        .hit_o(hit_o)
    );

    // Behavioural match: walk up the trailing ones to find the ignored span.
    function automatic bit ref_match(logic [31:0] p, bit sp, logic [31:0] s);
        int first_kept;
        if (!sp) return (s == p);
        first_kept = 0;
        while (first_kept < 32 && p[first_kept] == 1'b1) first_kept++;
        first_kept = first_kept + 1;
        for (int b = first_kept; b < 32; b++)
            if (s[b] != p[b]) return 0;
        return 1;
    endfunction

    // Reference model: evaluate with old settings, then apply the write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCTR; i++) begin
                m_pat[i]  = 32'hFFFF_FFFF;
                m_span[i] = 1;
            end
            m_exp = '0;
        end else begin
            for (int i = 0; i < NCTR; i++) begin
                int k;
                k = global_mode ? 0 : i;
                m_exp[i] = sid_valid && ref_match(m_pat[k], m_span[k], sid);
            end
            if (cfg_we) begin
                m_pat[cfg_idx]  = cfg_pattern;
                m_span[cfg_idx] = cfg_span;
            end
        end
        armed = 1;
    end

    task automatic check(string req, logic [NCTR-1:0] got, logic [NCTR-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: hit_o got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (armed && !done) check(cur_req, hit_o, m_exp);
    end

    task automatic send(logic [31:0] v);
        @(negedge clk);
        cfg_we = 0; sid_valid = 1; sid = v;
    endtask

    task automatic idle(logic [31:0] v);
        @(negedge clk);
        cfg_we = 0; sid_valid = 0; sid = v;
    endtask

    task automatic wr(int idx, logic [31:0] p, bit sp);
        @(negedge clk);
        sid_valid = 0; cfg_we = 1; cfg_idx = 2'(idx); cfg_pattern = p; cfg_span = sp;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1", hit_o, '0);
        cur_req = "R1";
        send(32'h0000_1234); send(32'h0); send(32'hFFFF_FFFF); send(32'hDEAD_BEEF);
        idle(0);

        cur_req = "R2";
        wr(0, 32'h0000_1000, 0);
        wr(1, 32'hFFFF_FFFF, 0);
        wr(2, 32'h0000_0042, 1);
        wr(3, 32'h0000_000F, 1);
        send(32'h0000_1000); send(32'h0000_1001); send(32'hFFFF_FFFF); send(32'hFFFF_FFFE);

        cur_req = "R3";
        send(32'h42); send(32'h43); send(32'h40); send(32'h44);
        send(32'h00); send(32'h1F); send(32'h20); send(32'h8000_0043);
        wr(3, 32'h7FFF_FFFF, 1);
        send(32'h1234_5678); send(32'h8000_0000);
        wr(3, 32'hFFFF_0000, 1);
        send(32'hFFFF_0001); send(32'hFFFF_0002); send(32'hFFFE_0000);
        idle(0);
        @(negedge clk);
        check("R3", hit_o, '0);

        cur_req = "R4";
        wr(3, 32'hFFFF_FFFF, 1);
        send(32'h0); send(32'h5555_AAAA); send(32'h8000_0001);
        @(negedge clk); sid_valid = 0;
        check("R4", hit_o[3] ? 4'b1000 : 4'b0000, 4'b1000);

        cur_req = "R5";
        idle(32'h0000_1000); idle(32'h42); idle(32'hFFFF_FFFF);
        @(negedge clk);
        check("R5", hit_o, '0);

        cur_req = "R7";
        @(negedge clk);
        cfg_we = 1; cfg_idx = 0; cfg_pattern = 32'h0000_2000; cfg_span = 0;
        sid_valid = 1; sid = 32'h0000_1000;
        send(32'h0000_1000); send(32'h0000_2000);

        cur_req = "R8";
        wr(1, 32'h0000_0077, 0);
        send(32'h77); send(32'h2000); send(32'h42); send(32'hFFFF_FFFF);

        cur_req = "R6";
        wr(0, 32'h0000_0042, 1);
        @(negedge clk); cfg_we = 0; global_mode = 1;
        send(32'h42); send(32'h43); send(32'h1000); send(32'h77);
        idle(0);
        @(negedge clk); global_mode = 0;
        send(32'h77);
        idle(0);
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog %s: got hang expected completion", cur_req);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule